// File: doc/BRIEF.md
# Register-File Packet Input Loader

This block sits between a field-extraction stage and a processor core. Upstream sends packet fields as a stream of 32-bit words. The loader writes those words directly into one of two I/O register banks through the core's register-file write port, so software never issues loads to fetch packet input. While software works on one bank, the next packet is loaded into the other.

Software does not use interrupts. It waits in a loop that jumps to the address held in general register 4. Once a bank is fully loaded and the core reports idle, the loader overwrites that register with a handler address. It takes the address from a 16-entry table indexed by the packet's 4-bit type tag, which breaks the loop. The core lowers its idle line while it processes the packet and raises it again when it is done. That rising edge returns the bank to the loader. A small configuration port fills the handler table.

A packet longer than a bank is cut into bank-sized pieces. Each piece is handed to software separately, with the same handler.

Top module: `pkt_in_loader`

## Requirements
- R1: After reset, `fld_ready_o` is 1, `rf_we_o` is 0 and `pkt_avail_o` is 0. Every handler table entry reads as 0.
- R2: A word accepted on a cycle with `fld_valid_i` and `fld_ready_o` both high appears on the write port in the next cycle. It has `rf_we_o`=1, `rf_gp_o`=0, `rf_bank_o` set to the bank being loaded, `rf_addr_o` set to the word's position in its piece (from 0), and `rf_wdata_o` set to the word.
- R3: A piece ends at the word marked `fld_last_i` or at the 32nd word, whichever comes first. The following word goes to the other bank at index 0. Loading starts in bank 0.
- R4: `fld_ready_o` is 0 while the bank selected for loading still holds an unfinished piece. Words offered while ready is low are not written.
- R5: When the oldest loaded piece has not been dispatched and `idle_i` is 1, the next cycle shows one write with `rf_gp_o`=1, `rf_addr_o`=4, and `rf_wdata_o` set to the table entry for the type tag carried by that piece's first word. This write comes after every word of that piece and happens once per piece.
- R6: In a cycle where the handler write of R5 is issued, `fld_ready_o` is 0.
- R7: `pkt_avail_o` is 1 exactly while a loaded piece waits for its handler write.
- R8: A rising edge of `idle_i` after a dispatch frees that piece's bank. Dispatch then moves to the other bank. Once all pieces have finished, ready is 1 and `pkt_avail_o` is 0.
- R9: A configuration write sets entry `cfg_idx_i` to `cfg_data_i`. Later dispatches of that type use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fld_valid_i | input | 1 | Field word valid |
| fld_ready_o | output | 1 | Loader can accept a word |
| fld_data_i | input | 32 | Field word |
| fld_type_i | input | 4 | Packet type tag, taken from a piece's first word |
| fld_last_i | input | 1 | Last word of packet |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_gp_o | output | 1 | 1: general register set, 0: I/O bank |
| rf_bank_o | output | 1 | I/O bank index for word writes |
| rf_addr_o | output | 5 | Register index |
| rf_wdata_o | output | 32 | Register write data |
| idle_i | input | 1 | Core idle indication |
| pkt_avail_o | output | 1 | Loaded piece awaiting dispatch |
| cfg_we_i | input | 1 | Handler table write strobe |
| cfg_idx_i | input | 4 | Handler table entry |
| cfg_data_i | input | 32 | Handler address |

## Verification
The assertions assume that `idle_i` only rises after the core has dropped it in response to a handler write. They also assume the type tag is steady across a packet's words. The bench's core model enforces both. It holds idle high until it sees a handler write, waits two cycles, drops idle for a configurable time, and then raises it again. Each packet is driven with a single constant tag. Long processing times force both banks full, so the stall path is exercised under these same rules.

// File: rtl/pil_pkg.sv
package pil_pkg;
  typedef enum logic [1:0] {
    BK_FREE   = 2'd0,
    BK_LOADED = 2'd1,
    BK_RUN    = 2'd2
  } bank_st_e;

  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/pil_dispatch_tbl.sv
module pil_dispatch_tbl #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TYPE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [TYPE_W-1:0] cfg_idx_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  input  logic [TYPE_W-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_addr_o
);
  localparam int unsigned N_ENT = 1 << TYPE_W;

  logic [DATA_W-1:0] ent_q [N_ENT];

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q[e] <= '0;
      else if (cfg_we_i && cfg_idx_i == TYPE_W'(e)) ent_q[e] <= cfg_data_i;
    end
  end

  assign rd_addr_o = ent_q[rd_idx_i];
endmodule

// File: rtl/pil_bank_ctrl.sv
module pil_bank_ctrl import pil_pkg::*; #(
  parameter int unsigned TYPE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              close_i,
  input  logic [TYPE_W-1:0] close_type_i,
  input  logic              idle_i,
  output logic              wr_bank_o,
  output logic              wr_busy_o,
  output logic              fire_o,
  output logic [TYPE_W-1:0] disp_type_o,
  output logic              pkt_avail_o
);
  bank_st_e          st_q  [NUM_BANKS];
  logic [TYPE_W-1:0] typ_q [NUM_BANKS];
  logic wr_b_q, pr_b_q, idle_q, done;

  assign wr_bank_o   = wr_b_q;
  assign wr_busy_o   = st_q[wr_b_q] != BK_FREE;
  assign pkt_avail_o = st_q[pr_b_q] == BK_LOADED;
  assign fire_o      = pkt_avail_o && idle_i;
  assign disp_type_o = typ_q[pr_b_q];
  // completion: idle rises while the dispatched bank is running
  assign done        = st_q[pr_b_q] == BK_RUN && idle_i && !idle_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[b]  <= BK_FREE;
        typ_q[b] <= '0;
      end else if (close_i && wr_b_q == 1'(b)) begin
        st_q[b]  <= BK_LOADED;
        typ_q[b] <= close_type_i;
      end else if (fire_o && pr_b_q == 1'(b)) begin
        st_q[b]  <= BK_RUN;
      end else if (done && pr_b_q == 1'(b)) begin
        st_q[b]  <= BK_FREE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_b_q <= 1'b0;
      pr_b_q <= 1'b0;
      idle_q <= 1'b1;
    end else begin
      if (close_i) wr_b_q <= ~wr_b_q;
      if (done)    pr_b_q <= ~pr_b_q;
      idle_q <= idle_i;
    end
  end
endmodule

// File: rtl/pil_word_loader.sv
module pil_word_loader #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned TYPE_W      = 4,
  parameter int unsigned IO_REGS     = 32,
  parameter int unsigned HANDLER_REG = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fld_valid_i,
  output logic                       fld_ready_o,
  input  logic [DATA_W-1:0]          fld_data_i,
  input  logic [TYPE_W-1:0]          fld_type_i,
  input  logic                       fld_last_i,
  input  logic                       wr_bank_i,
  input  logic                       wr_busy_i,
  input  logic                       fire_i,
  input  logic [DATA_W-1:0]          handler_i,
  output logic                       close_o,
  output logic [TYPE_W-1:0]          close_type_o,
  output logic                       rf_we_o,
  output logic                       rf_gp_o,
  output logic                       rf_bank_o,
  output logic [$clog2(IO_REGS)-1:0] rf_addr_o,
  output logic [DATA_W-1:0]          rf_wdata_o
);
  localparam int unsigned AW = $clog2(IO_REGS);

  logic [AW-1:0]     cnt_q;
  logic [TYPE_W-1:0] ptype_q;
  logic              acc;

  // the handler write owns the port for its cycle
  assign fld_ready_o  = !wr_busy_i && !fire_i;
  assign acc          = fld_valid_i && fld_ready_o;
  assign close_o      = acc && (fld_last_i || cnt_q == AW'(IO_REGS - 1));
  assign close_type_o = (cnt_q == '0) ? fld_type_i : ptype_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ptype_q <= '0;
    end else if (acc) begin
      if (cnt_q == '0) ptype_q <= fld_type_i;
      cnt_q <= close_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rf_we_o    <= 1'b0;
      rf_gp_o    <= 1'b0;
      rf_bank_o  <= 1'b0;
      rf_addr_o  <= '0;
      rf_wdata_o <= '0;
    end else begin
      rf_we_o <= fire_i || acc;
      if (fire_i) begin
        rf_gp_o    <= 1'b1;
        rf_bank_o  <= 1'b0;
        rf_addr_o  <= AW'(HANDLER_REG);
        rf_wdata_o <= handler_i;
      end else if (acc) begin
        rf_gp_o    <= 1'b0;
        rf_bank_o  <= wr_bank_i;
        rf_addr_o  <= cnt_q;
        rf_wdata_o <= fld_data_i;
      end
    end
  end
endmodule

// File: rtl/pkt_in_loader.sv
module pkt_in_loader #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned TYPE_W      = 4,
  parameter int unsigned IO_REGS     = 32,
  parameter int unsigned HANDLER_REG = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fld_valid_i,
  output logic                       fld_ready_o,
  input  logic [DATA_W-1:0]          fld_data_i,
  input  logic [TYPE_W-1:0]          fld_type_i,
  input  logic                       fld_last_i,
  output logic                       rf_we_o,
  output logic                       rf_gp_o,
  output logic                       rf_bank_o,
  output logic [$clog2(IO_REGS)-1:0] rf_addr_o,
  output logic [DATA_W-1:0]          rf_wdata_o,
  input  logic                       idle_i,
  output logic                       pkt_avail_o,
  input  logic                       cfg_we_i,
  input  logic [TYPE_W-1:0]          cfg_idx_i,
  input  logic [DATA_W-1:0]          cfg_data_i
);
  logic              wr_bank, wr_busy, fire, close;
  logic [TYPE_W-1:0] close_type, disp_type;
  logic [DATA_W-1:0] handler;

  pil_dispatch_tbl #(.DATA_W(DATA_W), .TYPE_W(TYPE_W)) u_tbl (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_idx_i, .cfg_data_i,
    .rd_idx_i (disp_type),
    .rd_addr_o(handler)
  );

  pil_bank_ctrl #(.TYPE_W(TYPE_W)) u_bank (
    .clk_i, .rst_ni,
    .close_i     (close),
    .close_type_i(close_type),
    .idle_i,
    .wr_bank_o   (wr_bank),
    .wr_busy_o   (wr_busy),
    .fire_o      (fire),
    .disp_type_o (disp_type),
    .pkt_avail_o
  );

  pil_word_loader #(
    .DATA_W(DATA_W), .TYPE_W(TYPE_W), .IO_REGS(IO_REGS), .HANDLER_REG(HANDLER_REG)
  ) u_load (
    .clk_i, .rst_ni, .fld_valid_i, .fld_ready_o, .fld_data_i, .fld_type_i, .fld_last_i,
    .wr_bank_i   (wr_bank),
    .wr_busy_i   (wr_busy),
    .fire_i      (fire),
    .handler_i   (handler),
    .close_o     (close),
    .close_type_o(close_type),
    .rf_we_o, .rf_gp_o, .rf_bank_o, .rf_addr_o, .rf_wdata_o
  );
endmodule

// File: rtl/pil_chk.sv
module pil_chk #(
  parameter int unsigned IO_REGS     = 32,
  parameter int unsigned HANDLER_REG = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       fld_valid_i,
  input logic                       fld_ready_o,
  input logic                       rf_we_o,
  input logic                       rf_gp_o,
  input logic [$clog2(IO_REGS)-1:0] rf_addr_o,
  input logic                       idle_i,
  input logic                       pkt_avail_o
);
  // R2
  word_write_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fld_valid_i && fld_ready_o |=> rf_we_o && !rf_gp_o);
  // R5
  handler_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o && rf_gp_o |-> rf_addr_o == ($clog2(IO_REGS))'(HANDLER_REG));
  // R5
  handler_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o && rf_gp_o |-> $past(pkt_avail_o) && $past(idle_i));
  // R6
  dispatch_stalls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_avail_o && idle_i |-> !fld_ready_o);
  // R7
  avail_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o && rf_gp_o |-> !pkt_avail_o);
endmodule

bind pkt_in_loader pil_chk #(.IO_REGS(IO_REGS), .HANDLER_REG(HANDLER_REG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fld_valid_i(fld_valid_i), .fld_ready_o(fld_ready_o),
  .rf_we_o(rf_we_o), .rf_gp_o(rf_gp_o), .rf_addr_o(rf_addr_o), .idle_i(idle_i),
  .pkt_avail_o(pkt_avail_o)
);

// File: tb/pkt_in_loader_tb_top.sv
module pkt_in_loader_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic fld_valid = 0, fld_last = 0, idle = 1, cfg_we = 0;
  logic [31:0] fld_data = 0, cfg_data = 0;
  logic [3:0] fld_type = 0, cfg_idx = 0;
  logic fld_ready, rf_we, rf_gp, rf_bank, pkt_avail;
  logic [4:0] rf_addr;
  logic [31:0] rf_wdata;

  int checks = 0, errors = 0, proc_len = 20, disp_seen = 0;
  logic [31:0] last_handler = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_in_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fld_valid_i(fld_valid), .fld_ready_o(fld_ready),
    .fld_data_i(fld_data), .fld_type_i(fld_type), .fld_last_i(fld_last),
    .rf_we_o(rf_we), .rf_gp_o(rf_gp), .rf_bank_o(rf_bank), .rf_addr_o(rf_addr),
    .rf_wdata_o(rf_wdata), .idle_i(idle), .pkt_avail_o(pkt_avail),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: bank states 0 free, 1 loaded, 2 running
  int m_st [2];
  int m_typ [2];
  int m_wb, m_pb, m_cnt, m_ctyp, m_chunks;
  bit m_idle_q;
  logic [31:0] m_tbl [16];
  bit e_we, e_gp, e_bank;
  int e_addr;
  logic [31:0] e_data;

  function automatic bit m_fire();
    return m_st[m_pb] == 1 && idle;
  endfunction
  function automatic bit m_rdy();
    return m_st[m_wb] == 0 && !m_fire();
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st[0] = 0; m_st[1] = 0; m_typ[0] = 0; m_typ[1] = 0;
      m_wb = 0; m_pb = 0; m_cnt = 0; m_ctyp = 0; m_chunks = 0; m_idle_q = 1;
      for (int k = 0; k < 16; k++) m_tbl[k] = 0;
      e_we = 0; e_gp = 0; e_bank = 0; e_addr = 0; e_data = 0;
    end else begin
      bit f, a, dn;
      int ct;
      f  = m_fire();
      a  = fld_valid && m_rdy();
      dn = m_st[m_pb] == 2 && idle && !m_idle_q;
      e_we = f || a;
      if (f) begin
        e_gp = 1; e_addr = 4; e_data = m_tbl[m_typ[m_pb]];
        m_st[m_pb] = 2;
      end else if (a) begin
        e_gp = 0; e_bank = m_wb[0]; e_addr = m_cnt; e_data = fld_data;
      end
      if (a) begin
        ct = (m_cnt == 0) ? int'(fld_type) : m_ctyp;
        if (m_cnt == 0) m_ctyp = int'(fld_type);
        if (fld_last || m_cnt == 31) begin
          m_st[m_wb] = 1; m_typ[m_wb] = ct; m_wb ^= 1; m_cnt = 0; m_chunks++;
        end else m_cnt++;
      end
      if (dn) begin m_st[m_pb] = 0; m_pb ^= 1; end
      if (cfg_we) m_tbl[cfg_idx] = cfg_data;
      m_idle_q = idle;
    end
  end

  // per-cycle comparison, well after the edge and after stimulus settles
  always @(negedge clk) begin
    if (rst_n) begin
      #3;
      chk(fld_ready == m_rdy(), "R4 R6", "ready", fld_ready, m_rdy());
      chk(pkt_avail == (m_st[m_pb] == 1), "R7", "pkt_avail", pkt_avail, m_st[m_pb] == 1);
      chk(rf_we == e_we, "R2 R5", "rf_we", rf_we, e_we);
      if (rf_we && e_we) begin
        chk(rf_gp == e_gp, "R5", "rf_gp", rf_gp, e_gp);
        chk(rf_addr == 5'(e_addr), "R2 R3 R5", "rf_addr", rf_addr, e_addr);
        chk(rf_wdata == e_data, "R2 R5 R9", "rf_wdata", rf_wdata, e_data);
        if (!e_gp) chk(rf_bank == e_bank, "R3", "rf_bank", rf_bank, e_bank);
      end
    end
  end

  // core model: answers a handler write by a busy period
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && rf_we && rf_gp) begin
        disp_seen++;
        last_handler = rf_wdata;
        repeat (2) @(negedge clk);
        #1 idle = 0;
        repeat (proc_len) @(negedge clk);
        #1 idle = 1;
      end
    end
  end

  task automatic send(int typ, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      fld_valid = 1; fld_type = 4'(typ); fld_last = (i == n - 1);
      fld_data = {8'(typ), 8'hA5, 16'(i)};
      #1;
      while (!fld_ready) begin @(negedge clk); #2; end
    end
    @(negedge clk); #1 fld_valid = 0; fld_last = 0;
  endtask

  task automatic cfg(int idx, logic [31:0] val);
    @(negedge clk); #1 cfg_we = 1; cfg_idx = 4'(idx); cfg_data = val;
    @(negedge clk); #1 cfg_we = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (m_st[0] == 0 && m_st[1] == 0 && idle) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        #4;
        // R1 reset state
        chk(fld_ready == 1, "R1", "ready in reset", fld_ready, 1);
        chk(rf_we == 0, "R1", "rf_we in reset", rf_we, 0);
        chk(pkt_avail == 0, "R1", "pkt_avail in reset", pkt_avail, 0);
        rst_n = 1;
        for (int k = 0; k < 16; k++) cfg(k, 32'h4000_0000 + 32'(k) * 32'h100);
        proc_len = 20;
        send(3, 10);
        send(5, 20);
        proc_len = 70;   // long work: both banks fill, input stalls (R4)
        send(7, 30);
        send(9, 40);     // split 32 + 8 (R3)
        drain();
        cfg(12, 32'hCAFE_0000);
        proc_len = 5;
        send(12, 1);
        drain();
        chk(last_handler == 32'hCAFE_0000, "R9", "reprogrammed handler",
            last_handler, 32'hCAFE_0000);
        send(2, 32);
        drain();
        chk(disp_seen == 7, "R5", "dispatch count", disp_seen, 7);
        chk(m_chunks == 7, "R3", "piece count", m_chunks, 7);
        chk(fld_ready == 1, "R8", "ready after drain", fld_ready, 1);
        chk(pkt_avail == 0, "R8", "pkt_avail after drain", pkt_avail, 0);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule